// File: doc/BRIEF.md
# Message-Signalled Interrupt Dispatcher with Deferred Vectors

This block sits between a function's interrupt sources and its bus-master write path. A source names a vector on a valid/ready request port. The block checks the vector against the live capability settings: the enable bit, the enabled vector count, the message address, the message data, and the optional per-vector mask. It then either emits one memory-write message on an outgoing valid/ready channel, drops the request with a one-cycle flag, or records the vector in a pending bit because its mask is set. The capability values arrive as plain inputs. The block owns only the pending bits and its own sequencing state.

The outgoing message carries a 64-bit address, a 32-bit data word and a 16-bit requester ID. The data word is a single little-endian dword: bits 7:0 form the lowest byte. When a configuration write is signalled with the function enabled and masking present, three things happen. Pending bits at or above the enabled count are discarded. A scan then walks the vectors from 0 upward. Each vector that is pending and now unmasked has its pending bit cleared and is sent as a message.

The controller has three states. In `ST_IDLE` the block accepts requests. In `ST_FLUSH` it waits for its one-entry request buffer to drain before a scan. In `ST_SCAN` it replays pending vectors, one index per cycle.

The transitions are:
- `IDLE->FLUSH` occurs on a qualifying configuration write while the buffer is occupied.
- `IDLE->SCAN` occurs on a qualifying configuration write while the buffer is empty.
- `FLUSH->SCAN` occurs once the buffer is empty.
- `FLUSH->IDLE` and `SCAN->IDLE` occur when the enable bit is cleared.
- `SCAN->SCAN` with the index reset to 0 occurs when another qualifying configuration write arrives.
- `SCAN->IDLE` occurs after the last enabled index has been handled.

Top module: `msi_dispatch`

## Requirements
- R1: After reset, `wr_valid` is 0, `req_ready` is 1, `req_drop` is 0 and `pend_o` is all zero.
- R2: While `cfg_enable` is 0, an accepted request issues no write and raises `req_drop` for the one cycle after acceptance.
- R3: The enabled count is 2^min(`cfg_log2_cnt`, log2 NVEC); a log2 value above 5 acts as 5 with the default NVEC=32. A request for a vector at or above the count issues no write and raises `req_drop` for one cycle.
- R4: `wr_data[31:16]` is zero. `wr_data[15:0]` is `cfg_data` with its low log2(count) bits replaced by the vector number, or `cfg_data` unchanged when the count is 1.
- R5: `wr_addr` is {`cfg_addr_hi`, `cfg_addr_lo`} when `cfg_addr64`=1 and {32'h0, `cfg_addr_lo`} otherwise. Bits 1:0 are always forced to 0.
- R6: Each message is one write that carries `cfg_rid` on `wr_rid`.
- R7: With `cfg_mask_cap`=1 and `cfg_mask[v]`=1, an in-range request for v sets `pend_o[v]` and issues no write.
- R8: With `cfg_mask_cap`=0, the mask is ignored, no pending bit is ever set, and a configuration write replays nothing.
- R9: On `cfg_write` with `cfg_enable`=1 and `cfg_mask_cap`=1, pending bits at or above the count are cleared. Then every pending, unmasked vector is sent in ascending order and its bit is cleared, while masked pending bits remain.
- R10: While `wr_valid`=1 and `wr_ready`=0, `wr_valid`, `wr_addr`, `wr_data` and `wr_rid` hold their values.
- R11: While the output is stalled, one further sendable request is accepted into a buffer and `req_ready` then drops to 0. The buffered message follows the stalled one in order.
- R12: In the cycle after a qualifying configuration write, and until the scan ends, `req_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Interrupt request valid |
| req_vec | input | 5 | Requested vector number |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_drop | output | 1 | One-cycle flag for a discarded request |
| cfg_enable | input | 1 | Message interrupts enabled |
| cfg_log2_cnt | input | 3 | log2 of the enabled vector count (clamped) |
| cfg_addr64 | input | 1 | Use the 64-bit address |
| cfg_addr_lo | input | 32 | Low message address |
| cfg_addr_hi | input | 32 | High message address |
| cfg_data | input | 16 | Message data base value |
| cfg_mask_cap | input | 1 | Per-vector masking present |
| cfg_mask | input | 32 | Per-vector mask bits |
| cfg_write | input | 1 | Pulse: configuration was written |
| cfg_rid | input | 16 | Requester ID of the function |
| pend_o | output | 32 | Pending bits |
| wr_valid | output | 1 | Outgoing write valid |
| wr_ready | input | 1 | Outgoing write accepted |
| wr_addr | output | 64 | Write address |
| wr_data | output | 32 | Write data word |
| wr_rid | output | 16 | Write requester ID |

## Verification
The hardest situation to reach is a replay scan that meets a stalled output partway through. In that case the scan must hold on a pending vector, keep `req_ready` low, and resume in ascending order once the sink accepts. The bench first parks vectors 3, 5 and 6 as pending under mask. It then holds `wr_ready` low, clears the masks on 3 and 5, and pulses `cfg_write`. This lets it observe the held first message and the blocked request port, and then the ordered pair of writes and the surviving pending bit 6. A second difficult case is pending bits that lie beyond a newly shrunk count. The bench reaches it by lowering the count before a configuration write and checking that the pending bits vanish without any write.

// File: rtl/msi_dispatch_pkg.sv
package msi_dispatch_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FLUSH = 2'd1,
        ST_SCAN  = 2'd2
    } disp_state_e;

endpackage

// File: rtl/msi_msg_build.sv
module msi_msg_build #(
    parameter int VW = 5
) (
    input  logic [VW-1:0] vec,
    input  logic [VW-1:0] cnt_mask,
    input  logic          addr64,
    input  logic [31:0]   addr_lo,
    input  logic [31:0]   addr_hi,
    input  logic [15:0]   data_base,
    output logic [63:0]   msg_addr,
    output logic [31:0]   msg_data
);
    logic [15:0] vmask16;
    logic [15:0] vec16;
    logic [31:0] lo_aligned;

    always_comb begin
        vmask16    = 16'(cnt_mask);
        vec16      = 16'(vec);
        lo_aligned = {addr_lo[31:2], 2'b00};
        msg_data   = {16'h0000, (data_base & ~vmask16) | (vec16 & vmask16)};
        msg_addr   = addr64 ? {addr_hi, lo_aligned} : {32'h0000_0000, lo_aligned};
    end
endmodule

// File: rtl/msi_pend_store.sv
module msi_pend_store #(
    parameter int NVEC = 32,
    parameter int VW   = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_en,
    input  logic [VW-1:0]   set_idx,
    input  logic            clr_en,
    input  logic [VW-1:0]   clr_idx,
    input  logic            trim_en,
    input  logic [VW-1:0]   cnt_mask,
    output logic [NVEC-1:0] pend_o
);
    logic [NVEC-1:0] pend_q;
    logic [NVEC-1:0] pend_d;
    logic [NVEC-1:0] keep;

    for (genvar i = 0; i < NVEC; i++) begin : g_keep
        assign keep[i] = ((VW'(i) & ~cnt_mask) == '0);
    end

    always_comb begin
        pend_d = pend_q;
        if (set_en)  pend_d[set_idx] = 1'b1;
        if (clr_en)  pend_d[clr_idx] = 1'b0;
        if (trim_en) pend_d = pend_d & keep;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pend_o = pend_q;

    // R9
    trim_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trim_en |=> ((pend_q & ~$past(keep)) == '0));

endmodule

// File: rtl/msi_out_slot.sv
module msi_out_slot (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [63:0] ld_addr,
    input  logic [31:0] ld_data,
    input  logic [15:0] ld_rid,
    input  logic        wr_ready,
    output logic        wr_valid,
    output logic [63:0] wr_addr,
    output logic [31:0] wr_data,
    output logic [15:0] wr_rid,
    output logic        slot_free
);
    assign slot_free = !wr_valid || wr_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_valid <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
            wr_rid   <= '0;
        end else if (load) begin
            wr_valid <= 1'b1;
            wr_addr  <= ld_addr;
            wr_data  <= ld_data;
            wr_rid   <= ld_rid;
        end else if (wr_ready) begin
            wr_valid <= 1'b0;
        end
    end

    // R10
    hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_rid)));

    // R4
    data_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_data[31:16] == 16'h0000));

    // R11
    load_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> slot_free);

endmodule

// File: rtl/msi_dispatch.sv
module msi_dispatch
    import msi_dispatch_pkg::*;
#(
    parameter int NVEC = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic [$clog2(NVEC)-1:0]   req_vec,
    output logic                      req_ready,
    output logic                      req_drop,
    input  logic                      cfg_enable,
    input  logic [$clog2($clog2(NVEC)+1)-1:0] cfg_log2_cnt,
    input  logic                      cfg_addr64,
    input  logic [31:0]               cfg_addr_lo,
    input  logic [31:0]               cfg_addr_hi,
    input  logic [15:0]               cfg_data,
    input  logic                      cfg_mask_cap,
    input  logic [NVEC-1:0]           cfg_mask,
    input  logic                      cfg_write,
    input  logic [15:0]               cfg_rid,
    output logic [NVEC-1:0]           pend_o,
    output logic                      wr_valid,
    input  logic                      wr_ready,
    output logic [63:0]               wr_addr,
    output logic [31:0]               wr_data,
    output logic [15:0]               wr_rid
);
    localparam int VW = $clog2(NVEC);
    localparam int LW = $clog2(VW + 1);
    localparam int CW = VW + 1;

    disp_state_e   state_q, state_d;
    logic [VW-1:0] idx_q, idx_d;
    logic          buf_valid, buf_vec_unused;
    logic [VW-1:0] buf_vec;
    logic          drop_q;

    logic [LW-1:0] eff_log;
    logic [CW-1:0] cnt_full;
    logic [VW-1:0] cnt_mask;

    logic accept, in_range, masked;
    logic acc_drop, acc_defer, acc_send;
    logic trim_en, scan_need;

    logic          load, buf_set, buf_clr, buf_drop, clr_en, adv;
    logic [VW-1:0] ld_vec;
    logic          slot_free;
    logic [63:0]   msg_addr;
    logic [31:0]   msg_data;

    assign buf_vec_unused = 1'b0;

    // enabled count, clamped to the implemented maximum
    always_comb begin
        eff_log  = (cfg_log2_cnt > LW'(VW)) ? LW'(VW) : cfg_log2_cnt;
        cnt_full = CW'(1) << eff_log;
        cnt_mask = VW'(cnt_full - CW'(1));
    end

    assign req_ready = (state_q == ST_IDLE) && !buf_valid;
    assign accept    = req_valid && req_ready;
    assign in_range  = ((req_vec & ~cnt_mask) == '0);
    assign masked    = cfg_mask_cap && cfg_mask[req_vec];
    assign acc_drop  = accept && (!cfg_enable || !in_range);
    assign acc_defer = accept && cfg_enable && in_range && masked;
    assign acc_send  = accept && cfg_enable && in_range && !masked;
    assign trim_en   = cfg_write && cfg_enable && cfg_mask_cap;
    assign scan_need = (state_q == ST_SCAN) && pend_o[idx_q] && !cfg_mask[idx_q];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // next state and scan index
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                idx_d = '0;
                if (trim_en) state_d = buf_valid ? ST_FLUSH : ST_SCAN;
            end
            ST_FLUSH: begin
                idx_d = '0;
                if (!cfg_enable)     state_d = ST_IDLE;
                else if (!buf_valid) state_d = ST_SCAN;
            end
            ST_SCAN: begin
                if (!cfg_enable) begin
                    state_d = ST_IDLE;
                end else if (trim_en) begin
                    idx_d = '0;
                end else if (adv) begin
                    if (idx_q >= cnt_mask) state_d = ST_IDLE;
                    else                   idx_d = idx_q + VW'(1);
                end
            end
            default: begin
                state_d = ST_IDLE;
                idx_d   = '0;
            end
        endcase
    end

    // output-side decisions: buffer first, then new request, then scan
    always_comb begin
        load     = 1'b0;
        ld_vec   = '0;
        buf_set  = 1'b0;
        buf_clr  = 1'b0;
        buf_drop = 1'b0;
        clr_en   = 1'b0;
        adv      = 1'b0;
        if (buf_valid) begin
            if (!cfg_enable) begin
                buf_clr  = 1'b1;
                buf_drop = 1'b1;
            end else if (slot_free) begin
                load    = 1'b1;
                ld_vec  = buf_vec;
                buf_clr = 1'b1;
            end
        end else if (acc_send) begin
            if (slot_free) begin
                load   = 1'b1;
                ld_vec = req_vec;
            end else begin
                buf_set = 1'b1;
            end
        end else if (state_q == ST_SCAN && cfg_enable && !trim_en) begin
            if (scan_need) begin
                if (slot_free) begin
                    load   = 1'b1;
                    ld_vec = idx_q;
                    clr_en = 1'b1;
                    adv    = 1'b1;
                end
            end else begin
                adv = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_valid <= 1'b0;
            buf_vec   <= '0;
            drop_q    <= 1'b0;
        end else begin
            drop_q <= acc_drop || buf_drop;
            if (buf_set) begin
                buf_valid <= 1'b1;
                buf_vec   <= req_vec;
            end else if (buf_clr) begin
                buf_valid <= 1'b0;
            end
        end
    end

    assign req_drop = drop_q | buf_vec_unused;

    msi_msg_build #(.VW(VW)) u_build (
        .vec       (ld_vec),
        .cnt_mask  (cnt_mask),
        .addr64    (cfg_addr64),
        .addr_lo   (cfg_addr_lo),
        .addr_hi   (cfg_addr_hi),
        .data_base (cfg_data),
        .msg_addr  (msg_addr),
        .msg_data  (msg_data)
    );

    msi_pend_store #(.NVEC(NVEC), .VW(VW)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (acc_defer),
        .set_idx  (req_vec),
        .clr_en   (clr_en),
        .clr_idx  (idx_q),
        .trim_en  (trim_en),
        .cnt_mask (cnt_mask),
        .pend_o   (pend_o)
    );

    msi_out_slot u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .ld_addr   (msg_addr),
        .ld_data   (msg_data),
        .ld_rid    (cfg_rid),
        .wr_ready  (wr_ready),
        .wr_valid  (wr_valid),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wr_rid    (wr_rid),
        .slot_free (slot_free)
    );

    // R2
    send_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_valid) |-> $past(cfg_enable));

    // R7
    defer_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_defer |=> pend_o[$past(req_vec)]);

    // R8
    no_new_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_mask_cap |=> ((pend_o & ~$past(pend_o)) == '0));

    // R12
    scan_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trim_en |=> !req_ready);

    // R11
    one_buffer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_send && wr_valid && !wr_ready) |=> (!req_ready && wr_valid));

endmodule

// File: tb/sim_msi_dispatch.sv
`timescale 1ns/1ps
module sim_msi_dispatch;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [4:0]  req_vec;
    logic        req_ready;
    logic        req_drop;
    logic        cfg_enable;
    logic [2:0]  cfg_log2_cnt;
    logic        cfg_addr64;
    logic [31:0] cfg_addr_lo;
    logic [31:0] cfg_addr_hi;
    logic [15:0] cfg_data;
    logic        cfg_mask_cap;
    logic [31:0] cfg_mask;
    logic        cfg_write;
    logic [15:0] cfg_rid;
    logic [31:0] pend_o;
    logic        wr_valid;
    logic        wr_ready;
    logic [63:0] wr_addr;
    logic [31:0] wr_data;
    logic [15:0] wr_rid;

    always #2.5 clk = ~clk;

    msi_dispatch u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_vec(req_vec), .req_ready(req_ready), .req_drop(req_drop),
        .cfg_enable(cfg_enable), .cfg_log2_cnt(cfg_log2_cnt), .cfg_addr64(cfg_addr64),
        .cfg_addr_lo(cfg_addr_lo), .cfg_addr_hi(cfg_addr_hi), .cfg_data(cfg_data),
        .cfg_mask_cap(cfg_mask_cap), .cfg_mask(cfg_mask), .cfg_write(cfg_write), .cfg_rid(cfg_rid),
        .pend_o(pend_o),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data), .wr_rid(wr_rid)
    );

    localparam int NT = 6;
    localparam logic [2:0]  T_LOG  [NT] = '{3'd0, 3'd2, 3'd5, 3'd5, 3'd7, 3'd3};
    localparam logic        T_A64  [NT] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
    localparam logic [15:0] T_DATA [NT] = '{16'hABCD, 16'h4565, 16'hFFFF, 16'h1234, 16'h8000, 16'h00F0};
    localparam logic [4:0]  T_VEC  [NT] = '{5'd0, 5'd2, 5'd0, 5'd31, 5'd17, 5'd5};
    localparam logic [63:0] T_EADR [NT] = '{64'h0000_0000_FEE0_1000, 64'h0000_0001_FEE0_1000,
                                           64'h0000_0000_FEE0_1000, 64'h0000_0001_FEE0_1000,
                                           64'h0000_0000_FEE0_1000, 64'h0000_0001_FEE0_1000};
    localparam logic [31:0] T_EDAT [NT] = '{32'h0000_ABCD, 32'h0000_4566, 32'h0000_FFE0,
                                           32'h0000_123F, 32'h0000_8011, 32'h0000_00F5};

    int n_chk = 0;
    int n_err = 0;
    int n_log = 0;
    logic [63:0] log_addr [64];
    logic [31:0] log_data [64];
    logic [15:0] log_rid  [64];

    always @(posedge clk) begin
        if (rst_n && wr_valid && wr_ready) begin
            log_addr[n_log % 64] <= wr_addr;
            log_data[n_log % 64] <= wr_data;
            log_rid[n_log % 64]  <= wr_rid;
            n_log <= n_log + 1;
        end
    end

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [4:0] v);
        @(negedge clk);
        req_valid = 1'b1;
        req_vec   = v;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_log(input int target);
        for (int k = 0; k < 200 && n_log < target; k++) @(negedge clk);
    endtask

    task automatic pulse_cfg;
        @(negedge clk);
        cfg_write = 1'b1;
        @(negedge clk);
        cfg_write = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
        $finish;
    end

    initial begin
        int base;
        rst_n = 1'b0; req_valid = 1'b0; req_vec = '0;
        cfg_enable = 1'b1; cfg_log2_cnt = 3'd0; cfg_addr64 = 1'b0;
        cfg_addr_lo = 32'hFEE0_1003; cfg_addr_hi = 32'h0000_0001; cfg_data = 16'h0;
        cfg_mask_cap = 1'b0; cfg_mask = '0; cfg_write = 1'b0; cfg_rid = 16'h0A18;
        wr_ready = 1'b1;
        step(4);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        chk("R1 wr_valid", wr_valid, 0);
        chk("R1 req_ready", req_ready, 1);
        chk("R1 pend_o", pend_o, 0);
        chk("R1 req_drop", req_drop, 0);

        // R3 R4 R5 R6 table of message formats
        for (int i = 0; i < NT; i++) begin
            cfg_log2_cnt = T_LOG[i];
            cfg_addr64   = T_A64[i];
            cfg_data     = T_DATA[i];
            base = n_log;
            send(T_VEC[i]);
            wait_log(base + 1);
            chk("R5 address", log_addr[base % 64], T_EADR[i]);
            chk("R4 data", log_data[base % 64], T_EDAT[i]);
            chk("R6 requester id", log_rid[base % 64], 16'h0A18);
        end
        chk("R3 clamp count", n_log, NT);

        // R2 disabled requests dropped
        cfg_enable = 1'b0; cfg_log2_cnt = 3'd3; base = n_log;
        send(5'd2);
        chk("R2 drop flag", req_drop, 1);
        step(1);
        chk("R2 drop one cycle", req_drop, 0);
        step(5);
        chk("R2 no write", n_log, base);
        cfg_enable = 1'b1;

        // R3 out-of-range vectors
        cfg_log2_cnt = 3'd2;
        send(5'd4);
        chk("R3 drop vec4 of 4", req_drop, 1);
        cfg_log2_cnt = 3'd0;
        send(5'd1);
        chk("R3 drop vec1 of 1", req_drop, 1);
        step(5);
        chk("R3 no write", n_log, base);

        // R7 masked vectors deferred
        cfg_mask_cap = 1'b1; cfg_log2_cnt = 3'd3; cfg_data = 16'h0100; cfg_addr64 = 1'b0;
        cfg_mask = 32'h0000_0068;
        send(5'd3); send(5'd5); send(5'd6);
        chk("R7 pending bits", pend_o, 32'h0000_0068);
        step(5);
        chk("R7 no write", n_log, base);

        // R9 R12 replay with stalled output
        wr_ready = 1'b0;
        cfg_mask = 32'h0000_0040;
        pulse_cfg();
        chk("R12 req_ready low in scan", req_ready, 0);
        step(10);
        chk("R9 first replay held", wr_data, 32'h0000_0103);
        chk("R12 still blocked", req_ready, 0);
        wr_ready = 1'b1;
        wait_log(base + 2);
        step(40);
        chk("R9 replay order 3", log_data[base % 64], 32'h0000_0103);
        chk("R9 replay order 5", log_data[(base + 1) % 64], 32'h0000_0105);
        chk("R9 masked stays pending", pend_o, 32'h0000_0040);
        chk("R12 ready after scan", req_ready, 1);
        base = n_log;

        // R9 pending beyond a shrunk count discarded
        cfg_log2_cnt = 3'd2;
        pulse_cfg();
        step(10);
        chk("R9 trim pending", pend_o, 0);
        chk("R9 trim no write", n_log, base);

        // R8 no masking capability
        cfg_log2_cnt = 3'd3;
        send(5'd6);
        chk("R8 setup pending", pend_o, 32'h0000_0040);
        cfg_mask_cap = 1'b0; cfg_mask = '0;
        pulse_cfg();
        step(12);
        chk("R8 no replay", n_log, base);
        chk("R8 pending untouched", pend_o, 32'h0000_0040);
        cfg_mask = 32'h0000_0004;
        send(5'd2);
        wait_log(base + 1);
        chk("R8 mask ignored", log_data[base % 64], 32'h0000_0102);
        chk("R8 no new pending", pend_o, 32'h0000_0040);
        base = n_log;

        // R10 R11 stall and one-entry buffer
        cfg_mask = '0; cfg_data = 16'h0200;
        wr_ready = 1'b0;
        send(5'd1);
        send(5'd2);
        chk("R11 req_ready low when buffered", req_ready, 0);
        chk("R10 held valid", wr_valid, 1);
        step(4);
        chk("R10 held data", wr_data, 32'h0000_0201);
        wr_ready = 1'b1;
        wait_log(base + 2);
        chk("R11 order first", log_data[base % 64], 32'h0000_0201);
        chk("R11 order second", log_data[(base + 1) % 64], 32'h0000_0202);
        step(2);
        chk("R11 ready restored", req_ready, 1);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule